// File: doc/BRIEF.md
# Multichannel DMA Start/Abort Engine

This block is a small memory-to-memory copy engine with several independent channels that share one memory port. Each channel holds a source address, a destination address, a byte count and two address modes. On a start command it moves the programmed number of bytes in beats of up to four bytes. Each beat is a read of the source followed by a write of the destination. A single command word on the 32-bit register bus starts or aborts any set of channels, picked by a bitmask.

Both sides of a transfer can step their address up or down by the element width, or keep it fixed. A fixed address suits a device FIFO. The element width is 1 to 4 bytes. When the count is not a multiple of the width, the last beat carries only the bytes that are left. The byte count register counts down while the transfer runs, so software can read how much is still to move. Abort takes effect on the next clock edge. Every channel has a done flag, an abort flag and an interrupt line.

Top module: `dmx_top`

## Requirements
- R1: After reset every channel register and flag reads 0 and no memory request is raised.
- R2: Register map. The command word is at 0x000: bit 31 = 1 aborts and bit 31 = 0 starts, and bits [NCH-1:0] select the channels. Channel c has a window at 0x100 + 0x40*c with these offsets: 0x10 status (bit0 done, bit1 abort, bit2 busy), 0x20 source mode, 0x24 destination mode, 0x28 source address, 0x2C destination address, 0x30 byte count. Both mode registers hold the address mode in bits [5:4]. The source mode register also holds the element width minus one in bits [1:0], and that width applies to both sides. Every field reads back as it was written.
- R3: Each beat reads min(width, remaining) bytes at the source address and then writes the same bytes at the destination address. mem_bytes gives the beat length, and the data sits at the low end of the 32-bit word.
- R4: After each beat each address changes according to its mode. Mode 0 adds the element width, mode 1 subtracts it, and mode 2 keeps the address.
- R5: The byte count falls by the bytes moved in each beat and can be read at any time. When it reaches 0, busy clears and the done flag and irq are set.
- R6: While a channel is busy, writes to its mode, address and count registers and further start commands have no effect.
- R7: An abort clears busy at the next clock edge and sets the abort and done flags. A memory operation already in flight completes, but no further write and no count update follow. An abort sent to an idle channel also sets both flags.
- R8: Starting a channel whose count is 0 sets done at once and makes no memory access.
- R9: Busy channels are served round-robin on the shared memory port, one beat each in turn.
- R10: If an abort arrives in the same cycle as the write acknowledge of a channel's final beat, the abort wins. The flags show abort and done, and the count keeps the size of that final beat.
- R11: A memory request keeps its address, direction and length stable until it is acknowledged.
- R12: Writing 1 to status bit0 or bit1 clears that flag. This is allowed while the channel is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata one cycle later |
| reg_addr | input | RAW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the beat |
| mem_bytes | output | 3 | Bytes in this beat (1 to 4) |
| mem_wdata | output | 32 | Write data, low-aligned |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data, low-aligned |
| irq | output | NCH | Per channel: done or abort flag set |

## Verification
The sharpest collision is an abort command that lands in the same cycle as the acknowledge of the channel's final write beat. The engine must then report an abort and leave the count at that beat's size, and must not report a clean finish. The bench provokes this by watching the memory port at the falling edge. When it sees the acknowledge for the last destination address, it drives the abort command in that same half cycle, so both are sampled on the same rising edge. The result is judged from the status and count registers read back afterwards. A second overlap, start commands and beat completions of other channels in the same cycle, occurs throughout the random multi-channel runs. Those runs are judged against a byte-level memory model.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int CMD_ADDR  = 'h000;
  localparam int WIN_BASE  = 'h100;
  localparam int WIN_SHIFT = 6;
  localparam int ABORT_BIT = 31;

  localparam logic [5:0] R_STAT  = 6'h10;
  localparam logic [5:0] R_SMODE = 6'h20;
  localparam logic [5:0] R_DMODE = 6'h24;
  localparam logic [5:0] R_SADDR = 6'h28;
  localparam logic [5:0] R_DADDR = 6'h2C;
  localparam logic [5:0] R_SIZE  = 6'h30;

  typedef enum logic [1:0] {AM_INC = 2'd0, AM_DEC = 2'd1, AM_FIX = 2'd2} amode_e;
  typedef enum logic [1:0] {MV_IDLE = 2'd0, MV_RD = 2'd1, MV_WR = 2'd2} mvst_e;
endpackage

// File: rtl/dmx_chan.sv
module dmx_chan
  import dmx_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int NW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [5:0]    cfg_ofs,
  input  logic [31:0]   cfg_wdata,
  input  logic          start,
  input  logic          abort,
  input  logic          beat_done,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [SW-1:0] size_q,
  output logic [NW-1:0] beat_n,
  output logic          busy_q,
  output logic          done_q,
  output logic          abt_q,
  output logic [31:0]   rd_val
);
  logic [1:0]    s_am, d_am, wsel;
  logic [NW-1:0] w;

  assign w      = NW'(wsel) + NW'(1);
  assign beat_n = (size_q < SW'(w)) ? NW'(size_q) : w;

  function automatic logic [AW-1:0] stepa(input logic [AW-1:0] a,
                                          input logic [1:0] m,
                                          input logic [NW-1:0] s);
    case (m)
      AM_INC:  return a + AW'(s);
      AM_DEC:  return a - AW'(s);
      default: return a;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      s_am <= '0; d_am <= '0; wsel <= '0;
      src_q <= '0; dst_q <= '0; size_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; abt_q <= 1'b0;
    end else begin
      if (cfg_we && !busy_q) begin
        case (cfg_ofs)
          R_SMODE: begin s_am <= cfg_wdata[5:4]; wsel <= cfg_wdata[1:0]; end
          R_DMODE: d_am   <= cfg_wdata[5:4];
          R_SADDR: src_q  <= cfg_wdata[AW-1:0];
          R_DADDR: dst_q  <= cfg_wdata[AW-1:0];
          R_SIZE:  size_q <= cfg_wdata[SW-1:0];
          default: ;
        endcase
      end
      if (cfg_we && cfg_ofs == R_STAT) begin
        if (cfg_wdata[0]) done_q <= 1'b0;
        if (cfg_wdata[1]) abt_q  <= 1'b0;
      end
      if (beat_done) begin
        size_q <= size_q - SW'(beat_n);
        src_q  <= stepa(src_q, s_am, w);
        dst_q  <= stepa(dst_q, d_am, w);
        if (size_q == SW'(beat_n)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
      if (start && !busy_q) begin
        if (size_q == '0) done_q <= 1'b1;
        else              busy_q <= 1'b1;
      end
      if (abort) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        abt_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (cfg_ofs)
      R_STAT:  rd_val[2:0]    = {busy_q, abt_q, done_q};
      R_SMODE: begin rd_val[5:4] = s_am; rd_val[1:0] = wsel; end
      R_DMODE: rd_val[5:4]    = d_am;
      R_SADDR: rd_val[AW-1:0] = src_q;
      R_DADDR: rd_val[AW-1:0] = dst_q;
      R_SIZE:  rd_val[SW-1:0] = size_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/dmx_rr.sv
module dmx_rr #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] gnt,
  output logic          any
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = last;
    for (int k = 1; k <= N; k++) begin
      if (!found && req[(int'(last) + k) % N]) begin
        found = 1'b1;
        gnt   = IW'((int'(last) + k) % N);
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/dmx_mover.sv
module dmx_mover
  import dmx_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int NW  = 3,
  parameter int CW  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          req_v,
  input  logic [NCH-1:0]          abort_v,
  input  logic [NCH-1:0][AW-1:0]  src_a,
  input  logic [NCH-1:0][AW-1:0]  dst_a,
  input  logic [NCH-1:0][NW-1:0]  n_a,
  input  logic                    mem_ack,
  input  logic [31:0]             mem_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [31:0]             mem_wdata,
  output logic [2:0]              mem_bytes,
  output logic [NCH-1:0]          beat_v
);
  mvst_e         st;
  logic [CW-1:0] cur, last, gnt;
  logic          gnt_any, kill;
  logic [AW-1:0] dst_l;

  dmx_rr #(.N(NCH), .IW(CW)) arb_i (
    .req(req_v), .last(last), .gnt(gnt), .any(gnt_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= MV_IDLE; cur <= '0; last <= '0; kill <= 1'b0;
      dst_l <= '0; mem_req <= 1'b0; mem_we <= 1'b0;
      mem_addr <= '0; mem_wdata <= '0; mem_bytes <= '0;
    end else begin
      case (st)
        MV_IDLE: begin
          kill <= 1'b0;
          if (gnt_any) begin
            cur       <= gnt;
            kill      <= abort_v[gnt];
            mem_addr  <= src_a[gnt];
            dst_l     <= dst_a[gnt];
            mem_bytes <= 3'(n_a[gnt]);
            mem_req   <= 1'b1;
            mem_we    <= 1'b0;
            st        <= MV_RD;
          end
        end
        MV_RD: begin
          if (abort_v[cur]) kill <= 1'b1;
          if (mem_ack) begin
            if (kill || abort_v[cur]) begin
              mem_req <= 1'b0;
              last    <= cur;
              st      <= MV_IDLE;
            end else begin
              mem_we    <= 1'b1;
              mem_addr  <= dst_l;
              mem_wdata <= mem_rdata;
              st        <= MV_WR;
            end
          end
        end
        default: begin
          if (abort_v[cur]) kill <= 1'b1;
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            last    <= cur;
            st      <= MV_IDLE;
          end
        end
      endcase
    end
  end

  always_comb begin
    beat_v = '0;
    if (st == MV_WR && mem_ack && !kill && !abort_v[cur]) beat_v[cur] = 1'b1;
  end
endmodule

// File: rtl/dmx_top.sv
module dmx_top
  import dmx_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int SW  = 16,
  parameter int RAW = 12,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int NW  = 3,
  localparam int IXW = RAW - WIN_SHIFT
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [2:0]     mem_bytes,
  output logic [31:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic [31:0]    mem_rdata,
  output logic [NCH-1:0] irq
);
  logic [NCH-1:0]         busy_v, done_v, abt_v, start_v, abort_v, beat_v, cfg_we_v;
  logic [NCH-1:0][AW-1:0] src_a, dst_a;
  logic [NCH-1:0][SW-1:0] size_a;
  logic [NCH-1:0][NW-1:0] n_a;
  logic [NCH-1:0][31:0]   rd_a;
  logic [RAW-1:0]         rel;
  logic [IXW-1:0]         win_idx;
  logic                   in_win, cmd_hit;

  assign rel     = reg_addr - RAW'(WIN_BASE);
  assign win_idx = rel[RAW-1:WIN_SHIFT];
  assign in_win  = (reg_addr >= RAW'(WIN_BASE)) && (win_idx < IXW'(NCH));
  assign cmd_hit = reg_wr && (reg_addr == RAW'(CMD_ADDR));
  assign start_v = (cmd_hit && !reg_wdata[ABORT_BIT]) ? reg_wdata[NCH-1:0] : '0;
  assign abort_v = (cmd_hit &&  reg_wdata[ABORT_BIT]) ? reg_wdata[NCH-1:0] : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cfg_we_v[c] = reg_wr && in_win && (win_idx == IXW'(c));
    dmx_chan #(.AW(AW), .SW(SW), .NW(NW)) ch_i (
      .clk(clk), .rst(rst),
      .cfg_we(cfg_we_v[c]), .cfg_ofs(reg_addr[5:0]), .cfg_wdata(reg_wdata),
      .start(start_v[c]), .abort(abort_v[c]), .beat_done(beat_v[c]),
      .src_q(src_a[c]), .dst_q(dst_a[c]), .size_q(size_a[c]), .beat_n(n_a[c]),
      .busy_q(busy_v[c]), .done_q(done_v[c]), .abt_q(abt_v[c]), .rd_val(rd_a[c])
    );
  end

  dmx_mover #(.NCH(NCH), .AW(AW), .NW(NW), .CW(CW)) mv_i (
    .clk(clk), .rst(rst), .req_v(busy_v), .abort_v(abort_v),
    .src_a(src_a), .dst_a(dst_a), .n_a(n_a),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_bytes(mem_bytes), .beat_v(beat_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= '0;
    end else begin
      irq <= done_v | abt_v;
      if (reg_rd) reg_rdata <= in_win ? rd_a[win_idx[CW-1:0]] : '0;
    end
  end
endmodule

// File: rtl/dmx_chk.sv
module dmx_chk #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int SW  = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   mem_req,
  input logic                   mem_ack,
  input logic                   mem_we,
  input logic [AW-1:0]          mem_addr,
  input logic [2:0]             mem_bytes,
  input logic [NCH-1:0]         busy_v,
  input logic [NCH-1:0]         done_v,
  input logic [NCH-1:0]         abt_v,
  input logic [NCH-1:0]         abort_v,
  input logic [NCH-1:0][SW-1:0] size_a
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_bytes));

  p_beat_len_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_bytes >= 3'd1 && mem_bytes <= 3'd4));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    p_abort_r7: assert property (@(posedge clk) disable iff (rst)
      abort_v[c] |=> !busy_v[c] && abt_v[c] && done_v[c]);

    p_finish_done_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_v[c]) |-> done_v[c]);

    p_finish_zero_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_v[c]) && !abt_v[c] |-> size_a[c] == '0);
  end
endmodule

bind dmx_top dmx_chk #(.NCH(NCH), .AW(AW), .SW(SW)) chk_i (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_bytes(mem_bytes), .busy_v(busy_v), .done_v(done_v),
  .abt_v(abt_v), .abort_v(abort_v), .size_a(size_a)
);

// File: tb/dmx_top_tb_top.sv
`timescale 1ns/1ps
module dmx_top_tb_top;
  localparam int NCH = 4;
  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [2:0]  mem_bytes;
  logic [NCH-1:0] irq;

  int checks = 0, errors = 0, nlog = 0;
  bit finished = 1'b0;
  logic [7:0] mem [256];
  logic [7:0] sh [256];
  int wlog [64];

  always #10 clk = ~clk;

  dmx_top #(.NCH(NCH)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_bytes(mem_bytes), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
  );

  // memory model: acknowledge one cycle after a request is seen
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (i < int'(mem_bytes)) mem[(mem_addr + i) & 255] <= mem_wdata[8*i +: 8];
        if (nlog < 64) wlog[nlog] <= int'(mem_addr[7:6]);
        nlog <= nlog + 1;
      end else begin
        for (int i = 0; i < 4; i++)
          mem_rdata[8*i +: 8] <= (i < int'(mem_bytes)) ? mem[(mem_addr + i) & 255] : 8'h00;
      end
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 12'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 12'(a);
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  function automatic int wb(input int c); return 'h100 + 'h40 * c; endfunction

  function automatic int stepf(input int a, input int m, input int w);
    if (m == 0) return a + w;
    if (m == 1) return a - w;
    return a;
  endfunction

  task automatic prog(input int c, input int sm, input int dm, input int w,
                      input int sa, input int da, input int sz);
    wr(wb(c) + 'h20, 32'((sm << 4) | (w - 1)));
    wr(wb(c) + 'h24, 32'(dm << 4));
    wr(wb(c) + 'h28, 32'(sa));
    wr(wb(c) + 'h2C, 32'(da));
    wr(wb(c) + 'h30, 32'(sz));
  endtask

  task automatic model(input int sa, input int da, input int sm, input int dm,
                       input int w, input int sz);
    while (sz > 0) begin
      int n;
      n = (sz < w) ? sz : w;
      for (int i = 0; i < n; i++) sh[(da + i) & 255] = sh[(sa + i) & 255];
      sz -= n;
      sa = stepf(sa, sm, w);
      da = stepf(da, dm, w);
    end
  endtask

  task automatic memcmp(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== sh[i]) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, 32'(mem[bad]), 32'(sh[bad]));
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) begin
      int t;
      t = 0;
      do begin rd(wb(c) + 'h10, v); t++; end while (v[2] && t < 3000);
      if (v[2]) chk(1'b0, "R5 idle", v, 0);
    end
  endtask

  task automatic clr_all();
    for (int c = 0; c < NCH; c++) wr(wb(c) + 'h10, 32'h3);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n0;
    bit hit;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'($urandom); sh[i] = mem[i]; end
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      rd(wb(c) + 'h10, v); chk(v == 0, "R1 status", v, 0);
    end
    rd(wb(2) + 'h30, v); chk(v == 0, "R1 size", v, 0);
    chk(mem_req == 1'b0 && irq == '0, "R1 port", {31'b0, mem_req}, 0);

    // R2 register map readback
    wr(wb(1) + 'h20, 32'h13); rd(wb(1) + 'h20, v); chk(v == 32'h13, "R2 smode", v, 32'h13);
    wr(wb(1) + 'h24, 32'h2F); rd(wb(1) + 'h24, v); chk(v == 32'h20, "R2 dmode", v, 32'h20);
    wr(wb(1) + 'h28, 32'hDEADBEEF); rd(wb(1) + 'h28, v); chk(v == 32'hDEADBEEF, "R2 saddr", v, 32'hDEADBEEF);
    wr(wb(1) + 'h2C, 32'h12345678); rd(wb(1) + 'h2C, v); chk(v == 32'h12345678, "R2 daddr", v, 32'h12345678);
    wr(wb(1) + 'h30, 32'hABCD); rd(wb(1) + 'h30, v); chk(v == 32'hABCD, "R2 size", v, 32'hABCD);

    // R3 R5 increment, partial last beat
    prog(0, 0, 0, 4, 0, 32, 10); model(0, 32, 0, 0, 4, 10);
    wr(0, 32'h1); wait_idle(); memcmp("R3 inc copy");
    rd(wb(0) + 'h30, v); chk(v == 0, "R5 size zero", v, 0);
    rd(wb(0) + 'h10, v); chk(v == 1, "R5 done flag", v, 1);
    chk(irq[0] == 1'b1, "R5 irq", {31'b0, irq[0]}, 1);

    // R4 decrement source, fixed destination
    prog(1, 1, 2, 2, 84, 104, 7); model(84, 104, 1, 2, 2, 7);
    wr(0, 32'h2); wait_idle(); memcmp("R4 dec/fixed copy");
    rd(wb(1) + 'h28, v); chk(v == 76, "R4 src stepped", v, 76);
    rd(wb(1) + 'h2C, v); chk(v == 104, "R4 dst held", v, 104);

    // R12 write-one-to-clear
    clr_all();
    rd(wb(0) + 'h10, v); chk(v == 0, "R12 clear", v, 0);

    // R5 live count, R6 writes while busy ignored
    prog(2, 0, 0, 1, 128, 160, 16); model(128, 160, 0, 0, 1, 16);
    wr(0, 32'h4); repeat (20) @(negedge clk);
    rd(wb(2) + 'h30, v); chk(v > 0 && v < 16, "R5 live count", v, 8);
    rd(wb(2) + 'h10, v); chk(v[2] == 1'b1, "R5 busy", v, 4);
    wr(wb(2) + 'h20, 32'h21); wr(wb(2) + 'h30, 32'h55); wr(0, 32'h4);
    rd(wb(2) + 'h20, v); chk(v == 0, "R6 mode locked", v, 0);
    wait_idle(); memcmp("R6 copy intact");
    rd(wb(2) + 'h30, v); chk(v == 0, "R6 size", v, 0);

    // R8 zero size start
    clr_all(); n0 = nlog;
    wr(0, 32'h8); rd(wb(3) + 'h10, v); chk(v == 1, "R8 done", v, 1);
    repeat (10) @(negedge clk); chk(nlog == n0, "R8 no traffic", nlog, n0);

    // R7 abort idle channel
    clr_all(); wr(0, 32'h8000_0008);
    rd(wb(3) + 'h10, v); chk(v == 3, "R7 abort idle", v, 3);

    // R7 abort busy channel
    clr_all();
    prog(0, 0, 0, 1, 0, 32, 30);
    wr(0, 32'h1); repeat (15) @(negedge clk);
    wr(0, 32'h8000_0001);
    rd(wb(0) + 'h10, v); chk(v == 3, "R7 abort busy", v, 3);
    repeat (3) @(negedge clk); n0 = nlog;
    repeat (30) @(negedge clk); chk(nlog == n0, "R7 port quiet", nlog, n0);
    rd(wb(0) + 'h30, v); chk(v > 0 && v < 30, "R7 count kept", v, 15);
    for (int i = 0; i < 256; i++) sh[i] = mem[i];

    // R10 abort meets final write acknowledge
    clr_all();
    prog(1, 0, 0, 4, 64, 96, 6); model(64, 96, 0, 0, 4, 6);
    wr(0, 32'h2); hit = 1'b0;
    for (int t = 0; t < 500 && !hit; t++) begin
      @(negedge clk);
      if (mem_ack && mem_we && mem_addr == 32'd100) begin
        reg_wr = 1'b1; reg_addr = 12'h000; reg_wdata = 32'h8000_0002; hit = 1'b1;
      end
    end
    @(negedge clk); reg_wr = 1'b0;
    chk(hit, "R10 provoked", {31'b0, hit}, 1);
    rd(wb(1) + 'h10, v); chk(v == 3, "R10 abort wins", v, 3);
    rd(wb(1) + 'h30, v); chk(v == 2, "R10 count kept", v, 2);
    memcmp("R10 data written");

    // R9 round-robin
    clr_all();
    for (int c = 0; c < NCH; c++) begin
      prog(c, 0, 0, 1, c * 64, c * 64 + 32, 4);
      model(c * 64, c * 64 + 32, 0, 0, 1, 4);
    end
    n0 = nlog;
    wr(0, 32'hF); wait_idle();
    for (int r = 0; r < 2; r++) begin
      logic [3:0] m;
      m = '0;
      for (int i = 0; i < NCH; i++) m[wlog[n0 + r * NCH + i]] = 1'b1;
      chk(m == 4'hF, "R9 rotation", 32'(m), 32'hF);
    end
    memcmp("R9 copies");

    // R3 R4 R5 random multi-channel runs
    for (int it = 0; it < 20; it++) begin
      clr_all();
      for (int c = 0; c < NCH; c++) begin
        int sm, dm, w, sz, sa, da;
        sm = int'($urandom_range(2, 0)); dm = int'($urandom_range(2, 0));
        w  = int'($urandom_range(4, 1)); sz = int'($urandom_range(12, 0));
        sa = c * 64 + ((sm == 0) ? 0 : (sm == 1) ? 20 : 4);
        da = c * 64 + ((dm == 0) ? 32 : (dm == 1) ? 52 : 40);
        prog(c, sm, dm, w, sa, da, sz);
        model(sa, da, sm, dm, w, sz);
      end
      wr(0, 32'hF); wait_idle();
      memcmp("R3 random copy");
      for (int c = 0; c < NCH; c++) begin
        rd(wb(c) + 'h30, v); chk(v == 0, "R5 random size", v, 0);
        rd(wb(c) + 'h10, v); chk(v == 1, "R4 random status", v, 1);
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule